// File: doc/BRIEF.md
# Matrix Operand Tile Access Sequencer

This block moves one square matrix operand between a 128-entry, 32-bit register array and a 16-slot tile buffer. Both memories sit outside the block and are read combinationally: the block drives an address to each one and a write strobe to whichever one receives data. A request carries a 7-bit operand specifier, a 2-bit size code, a direction (fill the tile from the array, or store the tile into the array) and a 4-bit write mask.

When a request is accepted, the sequencer visits the elements (i, j) of a 2x2, 3x3 or 4x4 sub-tile, one element per clock cycle. Row index i is the outer loop and column index j is the inner loop. For each element it forms the physical array index. Row and column positions wrap modulo 4 inside the selected 4x4 matrix, and the transpose bit swaps the roles of row and column. Element (i, j) always uses tile slot j*4+i, so the tile buffer holds the operand in column-major order. On a store, the write mask suppresses only elements in the last column. The block flags an illegal size code, which it then treats as 2x2. It also flags a store that carries a nonzero mask.

Top module: `mtx_tile_seq`

## Requirements
- R1: The size code selects the side: 1 gives 2, 2 gives 3 and 3 gives 4. Code 0 is illegal: `err_o` is set and the walk uses side 2.
- R2: Specifier bits [4:2] select the matrix and bits [1:0] the starting column. Bit 5 selects transpose. The starting row is 2*spec[6] for sides 2 and 4, and spec[6] for side 3.
- R3: Without transpose, element (i, j) uses array index mat*4 + ((col+j) mod 4) + ((row+i) mod 4)*32.
- R4: With transpose, element (i, j) uses array index mat*4 + ((row+i) mod 4) + ((col+j) mod 4)*32.
- R5: Element (i, j) always uses tile slot j*4 + i.
- R6: A start accepted at a clock edge makes `busy_o` high for exactly side*side cycles. Element (0,0) is presented in the first of these cycles, and the order is i outer and j inner. After reset, busy, done and both flags are low.
- R7: `done_o` is high for exactly one cycle, the cycle right after the last element, and never together with `busy_o`.
- R8: On a fill, every visited slot receives the array word at its index. The array is not written, and tile slots outside the side*side region keep their contents.
- R9: On a store, every visited element is written from its tile slot, except an element with j = side-1 whose mask bit i is set. Such an element keeps its old array contents.
- R10: `warn_o` is set for a store whose mask is nonzero. `err_o` and `warn_o` hold their values until the next accepted start.
- R11: A start request while `busy_o` is high is ignored: the running walk and its flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a transfer (taken only when idle) |
| store_i | input | 1 | 1 = tile to array, 0 = array to tile |
| spec_i | input | 7 | Operand specifier |
| size_i | input | 2 | Size code |
| wmask_i | input | 4 | Write mask, one bit per row i |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Illegal size code seen at the last start |
| warn_o | output | 1 | Store with nonzero mask at the last start |
| rf_addr_o | output | 7 | Register array index |
| rf_we_o | output | 1 | Register array write strobe |
| rf_wdata_o | output | DATA_W | Register array write data |
| rf_rdata_i | input | DATA_W | Register array read data |
| tb_addr_o | output | 4 | Tile buffer slot |
| tb_we_o | output | 1 | Tile buffer write strobe |
| tb_wdata_o | output | DATA_W | Tile buffer write data |
| tb_rdata_i | input | DATA_W | Tile buffer read data |

## Verification
Assertions check several properties on every cycle. Done is a single pulse and never overlaps busy. A start request while busy leaves the captured operand unchanged. The flags change only when a start is accepted. An illegal-size walk stays inside a 2x2 range. The two memories are never written in the same cycle. The exact index and slot sequence, the wrap and transpose arithmetic, the masked last-column skips and the untouched tile slots can only be shown by the bench scenarios. The bench compares them against its cycle model and against full memory images after each transfer.

// File: rtl/mtx_tile_pkg.sv
package mtx_tile_pkg;
    localparam int LANE_W = 2;              // row/column position inside a 4x4 matrix
    localparam int MAT_W  = 3;              // matrix select
    localparam int IDX_W  = 2 * LANE_W + MAT_W;
    localparam int SLOT_W = 2 * LANE_W;
    localparam int MASK_W = 1 << LANE_W;

    typedef enum logic [1:0] {
        SZC_BAD = 2'd0,
        SZC_2   = 2'd1,
        SZC_3   = 2'd2,
        SZC_4   = 2'd3
    } size_code_e;

    typedef struct packed {
        logic [MAT_W-1:0]  mat;
        logic [LANE_W-1:0] col;
        logic [LANE_W-1:0] row0;
        logic              tr;
        logic [LANE_W-1:0] last;   // side - 1
        logic              store;
        logic [MASK_W-1:0] mask;
    } walk_cfg_t;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [LANE_W-1:0] i;
        logic [LANE_W-1:0] j;
        walk_cfg_t         cfg;
        logic              err;
        logic              warn;
    } walk_state_t;
endpackage

// File: rtl/mtx_size_decode.sv
module mtx_size_decode
    import mtx_tile_pkg::*;
(
    input  logic [1:0]        code_i,
    input  logic              spec6_i,
    output logic [LANE_W-1:0] last_o,
    output logic [LANE_W-1:0] row0_o,
    output logic              err_o
);
    always_comb begin
        err_o  = 1'b0;
        last_o = LANE_W'(1);
        row0_o = {spec6_i, 1'b0};
        unique case (size_code_e'(code_i))
            SZC_BAD: err_o = 1'b1;
            SZC_2:   last_o = LANE_W'(1);
            SZC_3: begin
                last_o = LANE_W'(2);
                row0_o = {1'b0, spec6_i};
            end
            SZC_4:   last_o = LANE_W'(3);
            default: err_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/mtx_index_gen.sv
module mtx_index_gen
    import mtx_tile_pkg::*;
(
    input  logic [MAT_W-1:0]  mat_i,
    input  logic [LANE_W-1:0] col_i,
    input  logic [LANE_W-1:0] row0_i,
    input  logic              tr_i,
    input  logic [LANE_W-1:0] i_i,
    input  logic [LANE_W-1:0] j_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [SLOT_W-1:0] slot_o
);
    logic [LANE_W-1:0] r_pos, c_pos;

    always_comb begin
        r_pos  = row0_i + i_i;   // wraps modulo 4
        c_pos  = col_i + j_i;
        idx_o  = tr_i ? {c_pos, mat_i, r_pos} : {r_pos, mat_i, c_pos};
        slot_o = {j_i, i_i};
    end
endmodule

// File: rtl/mtx_walk_ctrl.sv
module mtx_walk_ctrl
    import mtx_tile_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  walk_cfg_t   cfg_i,
    input  logic        err_i,
    output walk_state_t st_o
);
    walk_state_t s_d, s_q;
    logic        accept;

    always_comb begin
        accept = start_i && !s_q.busy;
        s_d      = s_q;
        s_d.done = 1'b0;
        if (accept) begin
            s_d.busy = 1'b1;
            s_d.i    = '0;
            s_d.j    = '0;
            s_d.cfg  = cfg_i;
            s_d.err  = err_i;
            s_d.warn = cfg_i.store && (|cfg_i.mask);
        end else if (s_q.busy) begin
            if (s_q.j == s_q.cfg.last) begin
                s_d.j = '0;
                if (s_q.i == s_q.cfg.last) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.i = s_q.i + 1'b1;
                end
            end else begin
                s_d.j = s_q.j + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign st_o = s_q;

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);
    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.done && s_q.busy));
    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && start_i) |=> ($stable(s_q.cfg) && $stable(s_q.err) && $stable(s_q.warn)));
    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(s_q.err) && $stable(s_q.warn)));
    assert_bad_size_small_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.err) |-> (s_q.i <= LANE_W'(1) && s_q.j <= LANE_W'(1)));
endmodule

// File: rtl/mtx_tile_seq.sv
module mtx_tile_seq
    import mtx_tile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              store_i,
    input  logic [6:0]        spec_i,
    input  logic [1:0]        size_i,
    input  logic [3:0]        wmask_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              warn_o,
    output logic [6:0]        rf_addr_o,
    output logic              rf_we_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    input  logic [DATA_W-1:0] rf_rdata_i,
    output logic [3:0]        tb_addr_o,
    output logic              tb_we_o,
    output logic [DATA_W-1:0] tb_wdata_o,
    input  logic [DATA_W-1:0] tb_rdata_i
);
    walk_cfg_t         cfg_in;
    walk_state_t       st;
    logic [LANE_W-1:0] dec_last, dec_row0;
    logic              dec_err;
    logic              skip_el;

    mtx_size_decode u_dec (
        .code_i (size_i),
        .spec6_i(spec_i[6]),
        .last_o (dec_last),
        .row0_o (dec_row0),
        .err_o  (dec_err)
    );

    always_comb begin
        cfg_in.mat   = spec_i[4:2];
        cfg_in.col   = spec_i[1:0];
        cfg_in.tr    = spec_i[5];
        cfg_in.row0  = dec_row0;
        cfg_in.last  = dec_last;
        cfg_in.store = store_i;
        cfg_in.mask  = wmask_i;
    end

    mtx_walk_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .cfg_i  (cfg_in),
        .err_i  (dec_err),
        .st_o   (st)
    );

    mtx_index_gen u_idx (
        .mat_i (st.cfg.mat),
        .col_i (st.cfg.col),
        .row0_i(st.cfg.row0),
        .tr_i  (st.cfg.tr),
        .i_i   (st.i),
        .j_i   (st.j),
        .idx_o (rf_addr_o),
        .slot_o(tb_addr_o)
    );

    always_comb begin
        skip_el    = (st.j == st.cfg.last) && st.cfg.mask[st.i];
        busy_o     = st.busy;
        done_o     = st.done;
        err_o      = st.err;
        warn_o     = st.warn;
        rf_we_o    = st.busy && st.cfg.store && !skip_el;
        rf_wdata_o = tb_rdata_i;
        tb_we_o    = st.busy && !st.cfg.store;
        tb_wdata_o = rf_rdata_i;
    end

    assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we_o && tb_we_o));
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!rf_we_o && !tb_we_o));
    assert_slot_in_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && st.cfg.last == LANE_W'(2)) |-> (tb_addr_o[1:0] != 2'd3 && tb_addr_o[3:2] != 2'd3));
endmodule

// File: tb/mtx_tile_seq_test.sv
`timescale 1ns/1ps
module mtx_tile_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, store_i = 1'b0;
    logic [6:0]  spec_i = '0;
    logic [1:0]  size_i = '0;
    logic [3:0]  wmask_i = '0;
    logic        busy_o, done_o, err_o, warn_o, rf_we_o, tb_we_o;
    logic [6:0]  rf_addr_o;
    logic [3:0]  tb_addr_o;
    logic [31:0] rf_wdata_o, rf_rdata_i, tb_wdata_o, tb_rdata_i;

    logic [31:0] rf_mem [128];
    logic [31:0] tb_mem [16];
    logic [31:0] exp_rf [128];
    logic [31:0] exp_tb [16];

    int vectors = 0, misses = 0;
    int qa[$], qs[$], qrw[$], qtw[$];
    bit mbusy = 0, mdone = 0, merr = 0, mwarn = 0;

    always #2.5 clk = ~clk;

    mtx_tile_seq #(.DATA_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .store_i(store_i),
        .spec_i(spec_i), .size_i(size_i), .wmask_i(wmask_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .warn_o(warn_o),
        .rf_addr_o(rf_addr_o), .rf_we_o(rf_we_o), .rf_wdata_o(rf_wdata_o),
        .rf_rdata_i(rf_rdata_i), .tb_addr_o(tb_addr_o), .tb_we_o(tb_we_o),
        .tb_wdata_o(tb_wdata_o), .tb_rdata_i(tb_rdata_i)
    );

    assign rf_rdata_i = rf_mem[rf_addr_o];
    assign tb_rdata_i = tb_mem[tb_addr_o];

    always @(posedge clk) begin
        if (rf_we_o) rf_mem[rf_addr_o] <= rf_wdata_o;
        if (tb_we_o) tb_mem[tb_addr_o] <= tb_wdata_o;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Behavioural reference: builds the expected element list when a start is taken
    always @(posedge clk) begin
        if (!rst_n) begin
            mbusy = 0; mdone = 0; merr = 0; mwarn = 0;
            qa.delete(); qs.delete(); qrw.delete(); qtw.delete();
        end else begin
            mdone = 0;
            if (mbusy) begin
                if (qrw[0] != 0) exp_rf[qa[0]] = exp_tb[qs[0]];
                if (qtw[0] != 0) exp_tb[qs[0]] = exp_rf[qa[0]];
                void'(qa.pop_front()); void'(qs.pop_front());
                void'(qrw.pop_front()); void'(qtw.pop_front());
                if (qa.size() == 0) begin mbusy = 0; mdone = 1; end
            end else if (start_i) begin
                int side, row0, mat, col, tr;
                side = (size_i == 0) ? 2 : size_i + 1;          // R1
                merr = (size_i == 0);
                mwarn = store_i && (wmask_i != 0);               // R10
                mat = spec_i[4:2]; col = spec_i[1:0]; tr = spec_i[5];
                row0 = (side == 3) ? spec_i[6] : 2 * spec_i[6];  // R2
                for (int i = 0; i < side; i++)
                    for (int j = 0; j < side; j++) begin
                        int r, c;
                        r = (row0 + i) % 4; c = (col + j) % 4;
                        qa.push_back(tr ? mat*4 + r + c*32 : mat*4 + c + r*32); // R3 R4
                        qs.push_back(j*4 + i);                                   // R5
                        qrw.push_back((store_i && !(j == side-1 && wmask_i[i])) ? 1 : 0);
                        qtw.push_back(store_i ? 0 : 1);
                    end
                mbusy = 1;
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) if (rst_n) begin
        chk(busy_o == mbusy, "R6 busy", busy_o, mbusy);
        chk(done_o == mdone, "R7 done", done_o, mdone);
        chk(err_o == merr, "R1 err", err_o, merr);
        chk(warn_o == mwarn, "R10 warn", warn_o, mwarn);
        if (mbusy && qa.size() > 0) begin
            chk(rf_addr_o == qa[0], "R3 R4 index", rf_addr_o, qa[0]);
            chk(tb_addr_o == qs[0], "R5 slot", tb_addr_o, qs[0]);
            chk(rf_we_o == qrw[0], "R9 array write", rf_we_o, qrw[0]);
            chk(tb_we_o == qtw[0], "R8 tile write", tb_we_o, qtw[0]);
        end else begin
            chk(!rf_we_o && !tb_we_o, "R6 idle strobes", {rf_we_o, tb_we_o}, 0);
        end
    end

    task automatic check_mems(input string tag);
        for (int k = 0; k < 128; k++)
            chk(rf_mem[k] === exp_rf[k], {tag, " R9 array image"}, rf_mem[k], exp_rf[k]);
        for (int k = 0; k < 16; k++)
            chk(tb_mem[k] === exp_tb[k], {tag, " R8 tile image"}, tb_mem[k], exp_tb[k]);
    endtask

    task automatic preload_tile(input int seed);
        for (int k = 0; k < 16; k++) begin
            tb_mem[k] = 32'hB000_0000 + seed * 256 + k;
            exp_tb[k] = tb_mem[k];
        end
    endtask

    task automatic run_op(input bit st, input logic [6:0] sp, input logic [1:0] sz,
                          input logic [3:0] mk, input string tag);
        @(negedge clk);
        start_i = 1; store_i = st; spec_i = sp; size_i = sz; wmask_i = mk;
        @(negedge clk);
        start_i = 0;
        while (busy_o) @(negedge clk);
        @(negedge clk);
        check_mems(tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 128; k++) begin
            rf_mem[k] = 32'hA500_0000 ^ (k * 32'h0001_0203);
            exp_rf[k] = rf_mem[k];
        end
        preload_tile(0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy_o && !done_o && !err_o && !warn_o, "R6 reset state",
            {busy_o, done_o, err_o, warn_o}, 0);

        run_op(0, 7'b0_0_011_01, 2'd3, 4'h0, "R3 fill 4x4");
        run_op(0, 7'b1_1_110_11, 2'd3, 4'h0, "R4 fill 4x4 transposed wrap");
        preload_tile(1);
        run_op(0, 7'b1_0_010_10, 2'd2, 4'h0, "R2 fill 3x3 row1");
        preload_tile(2);
        run_op(0, 7'b0_1_111_00, 2'd2, 4'h0, "R4 fill 3x3 transposed");
        preload_tile(3);
        run_op(0, 7'b1_0_001_11, 2'd1, 4'h0, "R8 fill 2x2 slots kept");
        preload_tile(4);
        run_op(0, 7'b0_1_100_10, 2'd0, 4'h0, "R1 illegal size");
        preload_tile(5);
        run_op(1, 7'b0_0_010_00, 2'd3, 4'b0101, "R9 store 4x4 masked");
        preload_tile(6);
        run_op(1, 7'b1_1_000_01, 2'd2, 4'h0, "R9 store 3x3 unmasked");
        preload_tile(7);
        run_op(1, 7'b1_0_101_10, 2'd1, 4'b1111, "R10 store 2x2 full mask");
        preload_tile(8);
        run_op(1, 7'b0_1_011_11, 2'd3, 4'b1000, "R9 store transposed masked");

        // R11: a second request in the middle of a walk is ignored
        preload_tile(9);
        @(negedge clk);
        start_i = 1; store_i = 0; spec_i = 7'b0_0_001_00; size_i = 2'd3; wmask_i = 0;
        @(negedge clk);
        start_i = 0;
        repeat (3) @(negedge clk);
        start_i = 1; store_i = 1; spec_i = 7'b1_1_111_11; size_i = 2'd0; wmask_i = 4'hF;
        @(negedge clk);
        start_i = 0;
        while (busy_o) @(negedge clk);
        @(negedge clk);
        chk(!err_o && !warn_o, "R11 flags kept", {err_o, warn_o}, 0);
        check_mems("R11 busy start");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule